// File: doc/BRIEF.md
# Per-Core Interrupt CPU Interface with Split Priority Drop

This block sits between an interrupt distributor and one processor core. The distributor offers its single most urgent pending interrupt as an ID and an 8-bit priority, where a smaller number is more urgent. The block forwards that offer to the core as a registered request line. It does so only when the interface is enabled, the offer beats the software priority mask and the offer also beats the priority the core is currently running at.

Software talks to the block through a small register port. Reading the acknowledge register claims the signalled interrupt as a side effect. That interrupt is pushed onto a nested active-priority stack, and the running priority rises to its level. Writing the same ID to the end-of-interrupt register drops the running priority back to the next-older stacked level, or to idle (0xFF) when the stack is empty. A mode bit selects what else the end-of-interrupt write does. In combined mode it also deactivates the interrupt. In split mode the interrupt stays active until software writes its ID to a separate deactivate register. Acknowledge and deactivate events are reported to the distributor as one-cycle pulses carrying the ID.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset the request output is low, the running priority reads 0xFF, the control register reads 0 and the mask register reads 0.
- R2: The request output goes high only when all of the following hold: control bit 0 (enable) is set, an offer is valid, the offer's priority is numerically lower than the mask, and it is also lower than the running priority. The output is registered, so it follows these conditions with one cycle of delay.
- R3: A read at address 2 (acknowledge) while the request conditions hold returns the offered ID in bits 9:0. The same read pulses `ack_pulse` with that ID and raises the running priority (read at address 5) to the offer's priority. The request output is low in the cycle after the read.
- R4: An acknowledge read when the request conditions do not hold returns 1023. It changes no state and produces no `ack_pulse`. This applies to a repeated read and to a read with enable clear.
- R5: A write at address 3 (end-of-interrupt) whose value is not the ID on top of the active stack is ignored. Writing 0 is one such value. The running priority stays unchanged and no deactivation occurs.
- R6: With control bit 1 clear (combined mode), a matching end-of-interrupt write drops the running priority. In the same cycle it pulses `deact_pulse` with that ID.
- R7: With control bit 1 set (split mode), a matching end-of-interrupt write only drops the running priority. A later write of the same ID at address 4 (deactivate) pulses `deact_pulse`. A deactivate write for an ID that has not yet been dropped is ignored.
- R8: Preemption nests. After a drop, the running priority returns to the priority of the next-older active interrupt, or to 0xFF when none remains.
- R9: While DEPTH interrupts are active, including dropped-but-not-deactivated ones, no new interrupt is forwarded or acknowledged. A deactivation frees a slot again.
- R10: Address 0 holds the control register: bit 0 is enable and bit 1 is split mode. Address 1 holds the 8-bit priority mask. Both read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_valid | input | 1 | Distributor offers a pending interrupt |
| dist_id | input | 10 | ID of the offered interrupt |
| dist_prio | input | 8 | Priority of the offered interrupt (lower is more urgent) |
| irq | output | 1 | Registered interrupt request to the core |
| reg_en | input | 1 | Register access strobe, one access per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register select (0 ctrl, 1 mask, 2 ack, 3 eoi, 4 deact, 5 running) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| ack_pulse | output | 1 | Interrupt acknowledged this cycle |
| ack_id | output | 10 | ID acknowledged |
| deact_pulse | output | 1 | Interrupt deactivated this cycle |
| deact_id | output | 10 | ID deactivated |

## Verification
Some rules hold on every cycle, and the embedded assertions watch these. The request line is always low right after an acknowledge, and it is never high without the enable bit. A non-matching end-of-interrupt write leaves the running priority untouched. A split-mode drop always marks an entry that is present and not yet dropped, and neither storage structure is ever pushed when full or popped when empty. Other properties can only be shown by the bench's scenarios. These are the returned IDs, the strict comparison at the mask boundary and the nesting order of running priorities. They also include the difference between combined and split completion, and the recovery of capacity once a held interrupt is deactivated.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;

    typedef logic [ID_W-1:0]   irq_id_t;
    typedef logic [PRIO_W-1:0] prio_t;

    localparam irq_id_t SPURIOUS_ID = irq_id_t'(1023);
    localparam prio_t   IDLE_PRIO   = prio_t'(8'hFF);

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_MASK  = 3'd1,
        REG_ACK   = 3'd2,
        REG_EOI   = 3'd3,
        REG_DEACT = 3'd4,
        REG_RUN   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        irq_id_t id;
        prio_t   prio;
    } stk_entry_t;

    typedef struct packed {
        logic    busy;
        logic    dropped;
        irq_id_t id;
    } act_entry_t;

    function automatic logic beats(input prio_t cand, input prio_t ref_p);
        return cand < ref_p;
    endfunction
endpackage

// File: rtl/prio_stack.sv
module prio_stack
    import cpuif_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  stk_entry_t push_e,
    input  logic       pop,
    output stk_entry_t top_e,
    output logic       empty,
    output logic       full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    stk_entry_t     mem [DEPTH];
    logic [CW-1:0]  cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign top_e = empty ? '0 : mem[IW'(cnt - CW'(1))];

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (push && !full)
            cnt <= cnt + CW'(1);
        else if (pop && !empty)
            cnt <= cnt - CW'(1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && cnt == CW'(g))
                mem[g] <= push_e;
        end
    end

    // R9: never pushed beyond capacity
    a_r9_no_push_full: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R8: drops only happen with something stacked
    a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
    a_r8_count_bound:  assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH));
endmodule

// File: rtl/act_table.sv
module act_table
    import cpuif_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    alloc,
    input  irq_id_t alloc_id,
    input  irq_id_t key_id,
    input  logic    mark,
    input  logic    release_k,
    output logic    full,
    output logic    key_hit,
    output logic    key_dropped
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    act_entry_t       slot [DEPTH];
    logic [DEPTH-1:0] hit;
    logic [DEPTH-1:0] busy_v;
    logic [IW-1:0]    free_idx;

    always_comb begin
        free_idx    = '0;
        key_dropped = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            busy_v[i] = slot[i].busy;
            hit[i]    = slot[i].busy && (slot[i].id == key_id);
            if (!slot[i].busy) free_idx = IW'(i);
            if (hit[i] && slot[i].dropped) key_dropped = 1'b1;
        end
        full    = &busy_v;
        key_hit = |hit;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[g] <= '0;
            else if (alloc && !full && free_idx == IW'(g))
                slot[g] <= '{busy: 1'b1, dropped: 1'b0, id: alloc_id};
            else if (hit[g] && release_k)
                slot[g].busy <= 1'b0;
            else if (hit[g] && mark)
                slot[g].dropped <= 1'b1;
        end
    end

    // R9: allocation only with a free slot
    a_r9_alloc_room: assert property (@(posedge clk) disable iff (rst) alloc |-> !full);
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
    import cpuif_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        dist_valid,
    input  logic [9:0]  dist_id,
    input  logic [7:0]  dist_prio,
    output logic        irq,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        ack_pulse,
    output logic [9:0]  ack_id,
    output logic        deact_pulse,
    output logic [9:0]  deact_id
);
    logic       ctrl_en, ctrl_split;
    prio_t      mask_q;
    logic       irq_q;
    stk_entry_t top_e;
    logic       stk_empty, stk_full;
    logic       act_full, key_hit, key_dropped;
    prio_t      run_prio;
    logic       eligible, rd, wr, ack_take, eoi_hit, deact_hit, upper_zero;
    logic       mark, release_k;
    reg_sel_e   sel;

    assign sel        = reg_sel_e'(reg_addr);
    assign rd         = reg_en && !reg_we;
    assign wr         = reg_en && reg_we;
    assign upper_zero = (reg_wdata[31:ID_W] == '0);
    assign run_prio   = stk_empty ? IDLE_PRIO : top_e.prio;

    assign eligible = dist_valid && ctrl_en && beats(dist_prio, mask_q)
                      && beats(dist_prio, run_prio) && !act_full && !stk_full;
    assign ack_take = rd && sel == REG_ACK && eligible;
    assign eoi_hit  = wr && sel == REG_EOI && upper_zero && !stk_empty
                      && reg_wdata[ID_W-1:0] == top_e.id;
    assign deact_hit = wr && sel == REG_DEACT && upper_zero && key_hit && key_dropped;
    assign mark      = eoi_hit && ctrl_split;
    assign release_k = (eoi_hit && !ctrl_split) || deact_hit;

    prio_stack #(.DEPTH(DEPTH)) u_stack (
        .clk    (clk),
        .rst    (rst),
        .push   (ack_take),
        .push_e ('{id: dist_id, prio: dist_prio}),
        .pop    (eoi_hit),
        .top_e  (top_e),
        .empty  (stk_empty),
        .full   (stk_full)
    );

    act_table #(.DEPTH(DEPTH)) u_active (
        .clk         (clk),
        .rst         (rst),
        .alloc       (ack_take),
        .alloc_id    (dist_id),
        .key_id      (reg_wdata[ID_W-1:0]),
        .mark        (mark),
        .release_k   (release_k),
        .full        (act_full),
        .key_hit     (key_hit),
        .key_dropped (key_dropped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en    <= 1'b0;
            ctrl_split <= 1'b0;
            mask_q     <= '0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= eligible && !ack_take;
            if (wr && sel == REG_CTRL) begin
                ctrl_en    <= reg_wdata[0];
                ctrl_split <= reg_wdata[1];
            end
            if (wr && sel == REG_MASK)
                mask_q <= reg_wdata[PRIO_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (rd) begin
            unique case (sel)
                REG_CTRL: reg_rdata = {30'd0, ctrl_split, ctrl_en};
                REG_MASK: reg_rdata = {24'd0, mask_q};
                REG_ACK:  reg_rdata = {22'd0, ack_take ? dist_id : SPURIOUS_ID};
                REG_RUN:  reg_rdata = {24'd0, run_prio};
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign irq         = irq_q;
    assign ack_pulse   = ack_take;
    assign ack_id      = dist_id;
    assign deact_pulse = release_k;
    assign deact_id    = reg_wdata[ID_W-1:0];

    // R3: request is withdrawn right after being claimed
    a_r3_irq_low_after_ack: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> !irq);
    // R2: no request without the enable bit in the previous cycle
    a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ctrl_en));
    // R5: an unmatched end-of-interrupt leaves the running priority alone
    a_r5_bad_eoi_keeps_run: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == REG_EOI && !eoi_hit) |=> $stable(run_prio));
    // R7: a split drop always marks a present, not-yet-dropped entry
    a_r7_mark_consistent: assert property (@(posedge clk) disable iff (rst)
        mark |-> (key_hit && !key_dropped));
endmodule

// File: tb/irq_cpu_if_tb.sv
module irq_cpu_if_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        dist_valid;
    logic [9:0]  dist_id;
    logic [7:0]  dist_prio;
    logic        irq;
    logic        reg_en, reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        ack_pulse, deact_pulse;
    logic [9:0]  ack_id, deact_id;

    int total = 0;
    int bad   = 0;
    logic [31:0] lrd;
    logic        lap, ldp;

    logic [9:0] mid [8];
    logic [7:0] mpr [8];
    int         mcount;

    always #10 clk = ~clk;

    irq_cpu_if #(.DEPTH(8)) dut_i (
        .clk(clk), .rst(rst), .dist_valid(dist_valid), .dist_id(dist_id),
        .dist_prio(dist_prio), .irq(irq), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack_pulse(ack_pulse), .ack_id(ack_id), .deact_pulse(deact_pulse),
        .deact_id(deact_id)
    );

    function automatic logic [7:0] exp_run();
        return (mcount > 0) ? mpr[mcount-1] : 8'hFF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
        #5;
        lrd = reg_rdata; lap = ack_pulse; ldp = deact_pulse;
        @(posedge clk);
        #1;
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #5;
    endtask

    task automatic offer(input logic v, input logic [9:0] id, input logic [7:0] p);
        dist_valid = v; dist_id = id; dist_prio = p;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mcount = 0;
    endtask

    initial begin
        #4000000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_en = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        offer(0, 0, 0);
        do_reset();
        #5;
        check("R1 irq", irq, 0);
        acc(0, 5, 0); check("R1 running idle", lrd, 32'hFF);
        acc(0, 0, 0); check("R1 ctrl", lrd, 0);
        acc(0, 1, 0); check("R1 mask", lrd, 0);

        // R2/R4: disabled interface forwards nothing
        offer(1, 10'd33, 8'h40);
        settle(); check("R2 disabled irq", irq, 0);
        acc(0, 2, 0); check("R4 disabled ack spurious", lrd, 1023);
        check("R4 no ack pulse", lap, 0);

        // R10 register readback, R2 mask boundary
        acc(1, 0, 32'h1); acc(1, 1, 32'h40);
        acc(0, 0, 0); check("R10 ctrl readback", lrd, 1);
        acc(0, 1, 0); check("R10 mask readback", lrd, 32'h40);
        settle(); check("R2 equal mask blocks", irq, 0);
        acc(1, 1, 32'h41);
        settle(); check("R2 irq raised", irq, 1);

        // R3 acknowledge
        acc(0, 2, 0);
        check("R3 ack id", lrd, 33); check("R3 ack pulse", lap, 1);
        @(negedge clk); #5; check("R3 irq low after ack", irq, 0);
        acc(0, 5, 0); check("R3 running raised", lrd, 32'h40);
        acc(0, 2, 0); check("R4 second ack spurious", lrd, 1023);
        check("R4 second ack no pulse", lap, 0);

        // R8 nested preemption
        offer(1, 10'd50, 8'h20);
        settle(); check("R8 preempt irq", irq, 1);
        acc(0, 2, 0); check("R8 preempt ack", lrd, 50);
        offer(0, 0, 0);
        acc(1, 3, 0); check("R5 eoi zero no deact", ldp, 0);
        acc(0, 5, 0); check("R5 running kept", lrd, 32'h20);
        acc(1, 3, 50); check("R6 combined deact", ldp, 1);
        acc(0, 5, 0); check("R8 back to older", lrd, 32'h40);
        acc(1, 3, 33); check("R6 combined deact 33", ldp, 1);
        acc(0, 5, 0); check("R8 back to idle", lrd, 32'hFF);

        // R7 split mode
        acc(1, 0, 32'h3); acc(1, 1, 32'hFF);
        offer(1, 10'd7, 8'h10);
        acc(0, 2, 0); check("R7 ack", lrd, 7);
        offer(0, 0, 0);
        acc(1, 4, 7); check("R7 early deact ignored", ldp, 0);
        acc(1, 3, 7); check("R7 eoi no deact", ldp, 0);
        acc(0, 5, 0); check("R7 dropped running", lrd, 32'hFF);
        acc(1, 4, 7); check("R7 deact pulse", ldp, 1);
        acc(1, 4, 7); check("R7 repeat deact ignored", ldp, 0);

        // R9 capacity with dropped but active interrupts
        for (int k = 0; k < 8; k++) begin
            offer(1, 10'(200 + k), 8'h30);
            acc(0, 2, 0);
            if (lrd != 32'(200 + k)) check("R9 fill ack", lrd, 32'(200 + k));
            offer(0, 0, 0);
            acc(1, 3, 32'(200 + k));
        end
        offer(1, 10'd300, 8'h05);
        settle(); check("R9 full no irq", irq, 0);
        acc(0, 2, 0); check("R9 full ack spurious", lrd, 1023);
        acc(1, 4, 203); check("R9 deact frees", ldp, 1);
        settle(); check("R9 irq after free", irq, 1);

        // random phase, combined mode
        do_reset();
        acc(1, 0, 32'h1); acc(1, 1, 32'hFF);
        void'($urandom(32'd77));
        for (int it = 0; it < 300; it++) begin
            int r;
            r = int'($urandom % 4);
            if (r < 2) begin
                logic [7:0] p;
                logic       el;
                p = 8'($urandom);
                offer(1, 10'(100 + it), p);
                el = (p < 8'hFF) && (p < exp_run()) && (mcount < 8);
                acc(0, 2, 0);
                check("R3 random ack", lrd, el ? 32'(100 + it) : 32'd1023);
                if (el) begin mid[mcount] = 10'(100 + it); mpr[mcount] = p; mcount++; end
                offer(0, 0, 0);
            end else if (r == 2 && mcount > 0) begin
                acc(1, 3, 32'(mid[mcount-1]));
                check("R6 random deact", ldp, 1);
                mcount--;
            end else begin
                acc(1, 3, 32'd1000);
                check("R5 random bad eoi", ldp, 0);
            end
            acc(0, 5, 0);
            check("R8 random running", lrd, 32'(exp_run()));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule